// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Six Status Flags

This block combines a two-operand adder/subtractor and a bitwise logic unit with a status-flag generator. It sits in a processor datapath. Each cycle, a 3-bit operation code selects add, subtract, AND, OR or XOR on two `WIDTH`-bit operands. The result appears combinationally on the result port.

Alongside the result, the block derives six status flags:
- carry (unsigned range exceeded, or a borrow)
- overflow (signed range exceeded)
- sign
- zero
- auxiliary carry (out of the low nibble)
- parity (even count of ones in the low byte)

Carry and overflow are computed independently of each other, so all four combinations of the two can occur.

The flags are held in a flag register. The register takes a new set of flags on a clock edge when the update enable is high. Otherwise the flags keep their old values, so the result can be observed without disturbing the stored flags. `WIDTH` must be at least 8.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 gives result (A + B) mod 2^WIDTH. Operation code 1 gives result (A - B) mod 2^WIDTH. The result is combinational.
- R2: Operation codes 2, 3 and 4 give the bitwise AND, OR and XOR of A and B. Codes 5, 6 and 7 give an all-zero result and set flags like a logic operation.
- R3: The carry flag is the unsigned carry out of the sum on add. On subtract it is the borrow, which is set exactly when A < B as unsigned numbers.
- R4: The overflow flag on add is set when A and B have the same sign bit and the result's sign bit differs from it. On subtract it is set when A and B have different sign bits and the result's sign bit differs from A's.
- R5: The sign flag equals the result's most significant bit. The zero flag is set exactly when the result is all zeros.
- R6: The auxiliary flag on add is the carry out of bit 3. On subtract it is set exactly when A[3:0] < B[3:0].
- R7: The parity flag is set exactly when the low 8 bits of the result hold an even number of ones.
- R8: Operation codes 2 to 7 clear carry, overflow and auxiliary.
- R9: The flag outputs come from a register. On a rising clock edge with the update enable high, all six flags load together. With the enable low they keep their values. An active-low asynchronous reset clears all six flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 AND, 3 OR, 4 XOR, 5-7 zero |
| opnd_a | input | WIDTH | Operand A (minuend on subtract) |
| opnd_b | input | WIDTH | Operand B (subtrahend on subtract) |
| upd_en | input | 1 | Load the flag register on this edge |
| result | output | WIDTH | Combinational operation result |
| carry_f | output | 1 | Registered carry / borrow flag |
| ovf_f | output | 1 | Registered signed overflow flag |
| sign_f | output | 1 | Registered sign flag |
| zero_f | output | 1 | Registered zero flag |
| aux_f | output | 1 | Registered low-nibble carry / borrow flag |
| par_f | output | 1 | Registered even-parity flag (low byte) |

## Verification
The assertions assume that `op_sel`, both operands and `upd_en` are known values and stay steady from one rising edge to the next. A flag check compares the value registered on an edge with the inputs sampled at that same edge. The stimulus changes inputs only on falling edges and drives every input to a defined value before reset is released. The add and subtract sweeps are exhaustive over both 8-bit operands, and the logic sweeps use strided operand grids.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } flags_t;

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  // 1 when the byte has an even number of set bits
  function automatic logic byte_even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
// Adder split into low nibble, middle bits and top bit so that the carries
// into bit 4 and into the MSB are explicit wires.
module alu_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             c_nib,
  output logic             c_msb,
  output logic             c_out
);
  localparam int MIDW = WIDTH - 5;

  logic [WIDTH-1:0] b_eff;
  logic [4:0]       lo;
  logic [MIDW:0]    mid;
  logic [1:0]       top;

  always_comb begin
    b_eff = sub ? ~b : b;
    lo    = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, sub};
    mid   = {1'b0, a[WIDTH-2:4]} + {1'b0, b_eff[WIDTH-2:4]} + {{MIDW{1'b0}}, lo[4]};
    top   = {1'b0, a[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]} + {1'b0, mid[MIDW]};
    sum   = {top[0], mid[MIDW-1:0], lo[3:0]};
    c_nib = lo[4];
    c_msb = mid[MIDW];
    c_out = top[1];
  end
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
`timescale 1ns/1ps
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] res,
  input  logic             c_nib,
  input  logic             c_msb,
  input  logic             c_out,
  output flags_t           flg
);
  logic arith, is_sub;

  always_comb begin
    arith   = op_is_arith(op);
    is_sub  = (op == OP_SUB);
    // inverted raw carries on subtract are borrows
    flg.cf  = arith & (c_out ^ is_sub);
    flg.af  = arith & (c_nib ^ is_sub);
    flg.of  = arith & (c_msb ^ c_out);
    flg.sf  = res[WIDTH-1];
    flg.zf  = (res == '0);
    flg.pf  = byte_even_ones(res[7:0]);
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             upd_en,
  output logic [WIDTH-1:0] result,
  output logic             carry_f,
  output logic             ovf_f,
  output logic             sign_f,
  output logic             zero_f,
  output logic             aux_f,
  output logic             par_f
);
  logic [WIDTH-1:0] arith_sum, logic_res;
  logic             raw_cnib, raw_cmsb, raw_cout;
  flags_t           nxt_flags, cur_flags;

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a(opnd_a), .b(opnd_b), .sub(op_sel == OP_SUB),
    .sum(arith_sum), .c_nib(raw_cnib), .c_msb(raw_cmsb), .c_out(raw_cout)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op_sel), .a(opnd_a), .b(opnd_b), .res(logic_res)
  );

  assign result = op_is_arith(op_sel) ? arith_sum : logic_res;

  alu_flag_gen #(.WIDTH(WIDTH)) u_fgen (
    .op(op_sel), .res(result), .c_nib(raw_cnib), .c_msb(raw_cmsb),
    .c_out(raw_cout), .flg(nxt_flags)
  );

  alu_flag_reg u_freg (
    .clk(clk), .rst_n(rst_n), .load(upd_en), .d(nxt_flags), .q(cur_flags)
  );

  assign carry_f = cur_flags.cf;
  assign ovf_f   = cur_flags.of;
  assign sign_f  = cur_flags.sf;
  assign zero_f  = cur_flags.zf;
  assign aux_f   = cur_flags.af;
  assign par_f   = cur_flags.pf;
endmodule

// File: rtl/flag_alu_chk.sv
`timescale 1ns/1ps
module flag_alu_chk
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             upd_en,
  input logic [WIDTH-1:0] result,
  input logic             carry_f,
  input logic             ovf_f,
  input logic             sign_f,
  input logic             zero_f,
  input logic             aux_f,
  input logic             par_f,
  input flags_t           nxt_flags
);
  logic [5:0] fl_out;
  assign fl_out = {carry_f, ovf_f, sign_f, zero_f, aux_f, par_f};

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ADD) |-> (result == WIDTH'(opnd_a + opnd_b))); // R1

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_SUB) |=> (carry_f == ($past(opnd_a) < $past(opnd_b)))); // R3

  AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_ADD) |=> (ovf_f == (($past(opnd_a[WIDTH-1]) == $past(opnd_b[WIDTH-1]))
                                       && ($past(result[WIDTH-1]) != $past(opnd_a[WIDTH-1]))))); // R4

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (sign_f == $past(result[WIDTH-1]))); // R5

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (zero_f == ($past(result) == '0))); // R5

  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (par_f == ($countones($past(result[7:0])) % 2 == 0))); // R7

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !op_is_arith(op_sel)) |=> (!carry_f && !ovf_f && !aux_f)); // R8

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (fl_out == $past(nxt_flags))); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(fl_out)); // R9
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .upd_en(upd_en), .result(result), .carry_f(carry_f), .ovf_f(ovf_f),
  .sign_f(sign_f), .zero_f(zero_f), .aux_f(aux_f), .par_f(par_f),
  .nxt_flags(nxt_flags)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op_sel = 3'd0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic         upd_en = 1'b0;
  logic [W-1:0] result;
  logic         carry_f, ovf_f, sign_f, zero_f, aux_f, par_f;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flag_alu #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .upd_en(upd_en), .result(result), .carry_f(carry_f), .ovf_f(ovf_f),
    .sign_f(sign_f), .zero_f(zero_f), .aux_f(aux_f), .par_f(par_f)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, op_sel, opnd_a, opnd_b, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Reference model: {res, cf, of, af} returned through outputs
  task automatic model(input int op, input int a, input int b,
                       output int res, output int cf, output int of, output int af);
    int s;
    cf = 0; of = 0; af = 0;
    case (op)
      0: begin
        s = a + b; res = s % 256; cf = (s > 255);
        s = to_signed(a) + to_signed(b); of = (s > 127 || s < -128);
        af = ((a % 16) + (b % 16)) > 15;
      end
      1: begin
        res = (a - b + 256) % 256; cf = (a < b);
        s = to_signed(a) - to_signed(b); of = (s > 127 || s < -128);
        af = ((a % 16) < (b % 16));
      end
      2: res = a & b;
      3: res = a | b;
      4: res = a ^ b;
      default: res = 0;
    endcase
  endtask

  function automatic int even_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  task automatic apply(input int op, input int a, input int b);
    int er, ec, eo, ea;
    @(negedge clk);
    op_sel = op[2:0]; opnd_a = a[W-1:0]; opnd_b = b[W-1:0]; upd_en = 1'b1;
    @(posedge clk); #1;
    model(op, a, b, er, ec, eo, ea);
    if (op < 2) begin
      chk("R1 result", int'(result), er);
      chk("R3 carry", int'(carry_f), ec);
      chk("R4 overflow", int'(ovf_f), eo);
      chk("R6 aux", int'(aux_f), ea);
    end else begin
      chk("R2 result", int'(result), er);
      chk("R8 cleared carry/ovf/aux", int'({carry_f, ovf_f, aux_f}), 0);
    end
    chk("R5 sign", int'(sign_f), (er >= 128) ? 1 : 0);
    chk("R5 zero", int'(zero_f), (er == 0) ? 1 : 0);
    chk("R7 parity", int'(par_f), even_ones(er));
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset clears all flags
    chk("R9 reset flags", int'({carry_f, ovf_f, sign_f, zero_f, aux_f, par_f}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R9: flags hold while enable is low
    apply(0, 255, 1);  // carry, zero, aux, parity set
    held = {carry_f, ovf_f, sign_f, zero_f, aux_f, par_f};
    @(negedge clk);
    op_sel = 3'd0; opnd_a = 8'd100; opnd_b = 8'd100; upd_en = 1'b0;
    @(posedge clk); #1;
    chk("R9 hold flags", int'({carry_f, ovf_f, sign_f, zero_f, aux_f, par_f}), int'(held));
    chk("R1 result with enable low", int'(result), 200);

    // Named carry/overflow corner cases (all four combinations)
    apply(0, 15, 8);     // neither
    apply(0, 15, 245);   // carry only
    apply(0, 79, 64);    // overflow only
    apply(0, 218, 157);  // both
    apply(1, 128, 1);    // R4 sub overflow
    apply(5, 255, 255);  // R2 reserved code gives zero
    apply(7, 12, 3);

    // Exhaustive add and subtract
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply(op, a, b);

    // Strided logic sweeps
    for (int op = 2; op < 8; op++)
      for (int a = 0; a < 256; a += 7)
        for (int b = 0; b < 256; b += 9)
          apply(op, a, b);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule